// File: doc/BRIEF.md
# Prioritised Interrupt Selector

This block gathers 64 level-sensitive interrupt lines and gives the processor one request at a time. Each line has its own 8-bit priority byte, and a line can only take part while that byte is nonzero. Each line also has a mask bit and a software force bit. In every cycle the block looks for the strongest line that is allowed to request, and it registers a 3-bit request level and an 8-bit vector number for the processor.

Software reaches the block through a plain register port: a byte address, a write strobe with 32-bit write data, and read data that follows the address in the same cycle. The 64-bit pending, mask and force vectors are each split into an upper word and a lower word. The priority bytes take one byte address per line. One more address returns the vector that is being presented, so a handler can find out which line it is serving.

Top module: `ipc_top`

## Requirements
- R1: A line n is active when (src_irq[n] OR force bit n) is 1, its priority byte is nonzero and its mask bit is 0. No other line can win.
- R2: The winner is the active line with the largest priority byte. When priority bytes are equal, the line with the larger index wins.
- R3: cpu_vector is 64 + n for winning line n. When no line is active, cpu_vector is 24 and cpu_level is 0.
- R4: cpu_level is bits 2:0 of the winner's priority byte. Both outputs are registered: a change on an input or in a register shows on the outputs at the next rising clock edge, and not before it.
- R5: A read of 0x00 returns src_irq[63:32] and a read of 0x04 returns src_irq[31:0], live. Writes to these two addresses change nothing.
- R6: After reset, every mask bit is 1, force and all priority bytes are 0, cpu_vector is 24 and cpu_level is 0.
- R7: The priority byte of line n sits at address 0x40+n. It is written from bus_wdata[7:0] and read back in bits 7:0. Writing 0 takes the line out of arbitration, and writing a nonzero value brings it back.
- R8: A read of 0xe0 returns cpu_vector in bits 7:0, with bits 31:8 at 0.
- R9: The mask is written and read at 0x08 (bits 63:32) and 0x0c (bits 31:0). The force vector is written and read at 0x10 (bits 63:32) and 0x14 (bits 31:0). A force bit makes its line request exactly as a high src_irq would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_irq | input | 64 | Level-sensitive request lines |
| bus_addr | input | 8 | Register byte address |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cpu_level | output | 3 | Registered request level to the processor |
| cpu_vector | output | 8 | Registered vector number to the processor |

## Verification
A corrupted mask, force or priority byte shows up on the next clock edge, because the winner is recomputed from the stored state in every cycle. A bad byte or bit then appears as a wrong cpu_vector or cpu_level, or as a wrong word when the register is read back. A fault in the compare inside the search, such as a reversed tie rule or a skipped group of lines, only shows when the affected lines are the strongest ones. For that reason the bench sweeps every single line, sets up ties across all lines, and runs mixed random patterns. An output stage that is off by a cycle is caught by sampling both before and after the edge that follows each change.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    localparam int NUM_SRC   = 64;
    localparam int LVL_W     = 8;
    localparam int OUT_LVL_W = 3;
    localparam int VEC_W     = 8;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int IDX_W     = $clog2(NUM_SRC);
    localparam int GRP       = 8;
    localparam int NGRP      = NUM_SRC / GRP;

    localparam logic [VEC_W-1:0] VEC_BASE = 8'd64;
    localparam logic [VEC_W-1:0] VEC_IDLE = 8'd24;

    localparam logic [ADDR_W-1:0] A_PEND_HI = 8'h00;
    localparam logic [ADDR_W-1:0] A_PEND_LO = 8'h04;
    localparam logic [ADDR_W-1:0] A_MASK_HI = 8'h08;
    localparam logic [ADDR_W-1:0] A_MASK_LO = 8'h0c;
    localparam logic [ADDR_W-1:0] A_FRC_HI  = 8'h10;
    localparam logic [ADDR_W-1:0] A_FRC_LO  = 8'h14;
    localparam logic [ADDR_W-1:0] A_ACK     = 8'he0;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] lvl;
        logic [IDX_W-1:0] idx;
    } cand_t;

    // Priority-byte window: 0x40..0x7f
    function automatic logic in_lvl_win(logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:IDX_W] == 2'b01;
    endfunction

    // hi is the higher-numbered contender; it wins ties
    function automatic cand_t pick_cand(cand_t lo, cand_t hi);
        if (hi.valid && (!lo.valid || hi.lvl >= lo.lvl))
            return hi;
        return lo;
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(cand_t c);
        return c.valid ? VEC_BASE + VEC_W'(c.idx) : VEC_IDLE;
    endfunction

endpackage

// File: rtl/ipc_regs.sv
module ipc_regs
    import ipc_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wen,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               wdata,
    output logic [NUM_SRC-1:0]              mask_o,
    output logic [NUM_SRC-1:0]              force_o,
    output logic [NUM_SRC-1:0]              en_o,
    output logic [NUM_SRC-1:0][LVL_W-1:0]   lvl_o
);
    localparam int HALF = NUM_SRC / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_o  <= '1;
            force_o <= '0;
            en_o    <= '0;
            lvl_o   <= '0;
        end else if (wen) begin
            case (addr)
                A_PEND_HI, A_PEND_LO: ;
                A_MASK_HI: mask_o[NUM_SRC-1:HALF] <= wdata[HALF-1:0];
                A_MASK_LO: mask_o[HALF-1:0]       <= wdata[HALF-1:0];
                A_FRC_HI:  force_o[NUM_SRC-1:HALF] <= wdata[HALF-1:0];
                A_FRC_LO:  force_o[HALF-1:0]       <= wdata[HALF-1:0];
                default: begin
                    if (in_lvl_win(addr)) begin
                        lvl_o[addr[IDX_W-1:0]] <= wdata[LVL_W-1:0];
                        en_o[addr[IDX_W-1:0]]  <= |wdata[LVL_W-1:0];
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/ipc_arbiter.sv
module ipc_arbiter
    import ipc_pkg::*;
(
    input  logic [NUM_SRC-1:0]            active,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
    output cand_t                         win
);
    cand_t grp_win [NGRP];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        cand_t best_c;
        cand_t leaf;
        always_comb begin
            best_c = '0;
            leaf   = '0;
            for (int j = 0; j < GRP; j++) begin
                leaf.valid = active[g*GRP + j];
                leaf.lvl   = lvl[g*GRP + j];
                leaf.idx   = IDX_W'(g*GRP + j);
                best_c     = pick_cand(best_c, leaf);
            end
        end
        assign grp_win[g] = best_c;
    end

    always_comb begin
        win = '0;
        for (int g = 0; g < NGRP; g++)
            win = pick_cand(win, grp_win[g]);
    end

endmodule

// File: rtl/ipc_rdmux.sv
module ipc_rdmux
    import ipc_pkg::*;
(
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_SRC-1:0]            pend,
    input  logic [NUM_SRC-1:0]            mask,
    input  logic [NUM_SRC-1:0]            frc,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
    input  logic [VEC_W-1:0]              vec,
    output logic [DATA_W-1:0]             rdata
);
    localparam int HALF = NUM_SRC / 2;

    always_comb begin
        rdata = '0;
        case (addr)
            A_PEND_HI: rdata = pend[NUM_SRC-1:HALF];
            A_PEND_LO: rdata = pend[HALF-1:0];
            A_MASK_HI: rdata = mask[NUM_SRC-1:HALF];
            A_MASK_LO: rdata = mask[HALF-1:0];
            A_FRC_HI:  rdata = frc[NUM_SRC-1:HALF];
            A_FRC_LO:  rdata = frc[HALF-1:0];
            A_ACK:     rdata = DATA_W'(vec);
            default: begin
                if (in_lvl_win(addr))
                    rdata = DATA_W'(lvl[addr[IDX_W-1:0]]);
            end
        endcase
    end

endmodule

// File: rtl/ipc_top.sv
module ipc_top
    import ipc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   src_irq,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wen,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [OUT_LVL_W-1:0] cpu_level,
    output logic [VEC_W-1:0]     cpu_vector
);
    logic [NUM_SRC-1:0]            mask_w;
    logic [NUM_SRC-1:0]            force_w;
    logic [NUM_SRC-1:0]            en_w;
    logic [NUM_SRC-1:0][LVL_W-1:0] lvl_w;
    logic [NUM_SRC-1:0]            active_w;
    cand_t                         win_w;

    ipc_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wen     (bus_wen),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .mask_o  (mask_w),
        .force_o (force_w),
        .en_o    (en_w),
        .lvl_o   (lvl_w)
    );

    assign active_w = (src_irq | force_w) & en_w & ~mask_w;

    ipc_arbiter u_arb (
        .active (active_w),
        .lvl    (lvl_w),
        .win    (win_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_level  <= '0;
            cpu_vector <= VEC_IDLE;
        end else begin
            cpu_level  <= win_w.valid ? win_w.lvl[OUT_LVL_W-1:0] : '0;
            cpu_vector <= vec_of(win_w);
        end
    end

    ipc_rdmux u_rd (
        .addr  (bus_addr),
        .pend  (src_irq),
        .mask  (mask_w),
        .frc   (force_w),
        .lvl   (lvl_w),
        .vec   (cpu_vector),
        .rdata (bus_rdata)
    );

endmodule

// File: rtl/ipc_checker.sv
module ipc_checker
    import ipc_pkg::*;
(
    input logic                            clk,
    input logic                            rst,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic [DATA_W-1:0]               bus_rdata,
    input logic [OUT_LVL_W-1:0]            cpu_level,
    input logic [VEC_W-1:0]                cpu_vector,
    input logic [NUM_SRC-1:0]              active,
    input logic [NUM_SRC-1:0]              mask,
    input logic [NUM_SRC-1:0]              en,
    input logic [NUM_SRC-1:0][LVL_W-1:0]   lvl,
    input cand_t                           win
);
    logic [NUM_SRC-1:0] nz;
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++)
            nz[i] = |lvl[i];
    end

    AST_IDLE_OUT: assert property (@(posedge clk) disable iff (rst)
        (active == '0) |=> (cpu_vector == VEC_IDLE && cpu_level == '0)); // R3
    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cpu_vector == VEC_IDLE) || (cpu_vector >= VEC_BASE && int'(cpu_vector) < int'(VEC_BASE) + NUM_SRC)); // R3
    AST_WIN_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        win.valid |-> active[win.idx]); // R1
    AST_LEVEL_PASS: assert property (@(posedge clk) disable iff (rst)
        win.valid |=> (cpu_level == $past(win.lvl[OUT_LVL_W-1:0]))); // R4
    AST_ACK_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_ACK) |-> (bus_rdata == DATA_W'(cpu_vector))); // R8
    AST_RESET_MASK: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (&mask)); // R6
    AST_ENABLE_TRACK: assert property (@(posedge clk) disable iff (rst)
        en == nz); // R7

endmodule

bind ipc_top ipc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .cpu_level  (cpu_level),
    .cpu_vector (cpu_vector),
    .active     (active_w),
    .mask       (mask_w),
    .en         (en_w),
    .lvl        (lvl_w),
    .win        (win_w)
);

// File: tb/ipc_top_bench.sv
`timescale 1ns/1ps
module ipc_top_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] src_irq;
    logic [7:0]  bus_addr;
    logic        bus_wen;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [2:0]  cpu_level;
    logic [7:0]  cpu_vector;

    always #2 clk = ~clk;

    ipc_top u_ipc_top (
        .clk        (clk),
        .rst        (rst),
        .src_irq    (src_irq),
        .bus_addr   (bus_addr),
        .bus_wen    (bus_wen),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cpu_level  (cpu_level),
        .cpu_vector (cpu_vector)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [7:0]  m_lvl [64];
    logic [63:0] m_mask, m_frc;
    logic [31:0] seed = 32'h1234_5678;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wen   = 1'b1;
        @(negedge clk);
        bus_wen   = 1'b0;
        case (a)
            8'h08: m_mask[63:32] = d;
            8'h0c: m_mask[31:0]  = d;
            8'h10: m_frc[63:32]  = d;
            8'h14: m_frc[31:0]   = d;
            default: if (a[7:6] == 2'b01) m_lvl[a[5:0]] = d[7:0];
        endcase
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic expect_out(string tag);
        int best = -1;
        logic [7:0] bl = 8'd0;
        for (int i = 0; i < 64; i++) begin
            if ((src_irq[i] | m_frc[i]) && !m_mask[i] && m_lvl[i] != 8'd0 && m_lvl[i] >= bl) begin
                bl   = m_lvl[i];
                best = i;
            end
        end
        if (best < 0) begin
            chk({tag, " vector"}, 32'(cpu_vector), 32'd24);
            chk({tag, " level"},  32'(cpu_level),  32'd0);
        end else begin
            chk({tag, " vector"}, 32'(cpu_vector), 32'(64 + best));
            chk({tag, " level"},  32'(cpu_level),  32'(bl[2:0]));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] r;
        rst = 1'b1; src_irq = '0; bus_addr = '0; bus_wen = 1'b0; bus_wdata = '0;
        m_mask = '1; m_frc = '0;
        for (int i = 0; i < 64; i++) m_lvl[i] = 8'd0;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R6: reset state
        chk("R6 vector", 32'(cpu_vector), 32'd24);
        chk("R6 level",  32'(cpu_level),  32'd0);
        rd(8'h08, d); chk("R6 mask hi", d, 32'hffff_ffff);
        rd(8'h0c, d); chk("R6 mask lo", d, 32'hffff_ffff);
        rd(8'h10, d); chk("R6 force hi", d, 32'h0);
        rd(8'h14, d); chk("R6 force lo", d, 32'h0);
        rd(8'h40, d); chk("R6 prio 0", d, 32'h0);
        rd(8'h7f, d); chk("R6 prio 63", d, 32'h0);

        // R7: priority bytes programmed and read back
        for (int i = 0; i < 64; i++) wr(8'(8'h40 + i), 32'(i % 7 + 1) | 32'hffff_ff00);
        for (int i = 0; i < 64; i += 9) begin
            rd(8'(8'h40 + i), d);
            chk("R7 prio readback", d, 32'(i % 7 + 1));
        end

        // R4: line waiting, unmask; output holds one edge, then changes
        src_irq = 64'h1 << 5;
        step();
        chk("R4 masked still idle", 32'(cpu_vector), 32'd24);
        wr(8'h0c, 32'h0);
        chk("R4 not before edge", 32'(cpu_vector), 32'd24);
        step();
        chk("R4 after edge", 32'(cpu_vector), 32'd69);
        wr(8'h08, 32'h0);
        step();

        // R3 / R1: every single line alone
        for (int i = 0; i < 64; i++) begin
            src_irq = 64'h1 << i;
            step();
            expect_out("R3 sweep");
        end
        src_irq = '0;
        step();
        expect_out("R3 idle");

        // R2: all equal -> highest index
        for (int i = 0; i < 64; i++) wr(8'(8'h40 + i), 32'd5);
        src_irq = '1;
        step();
        chk("R2 tie vector", 32'(cpu_vector), 32'd127);
        chk("R2 tie level",  32'(cpu_level),  32'd5);
        // R2: lower line with higher priority beats higher line
        wr(8'h40 + 8'd2, 32'd6);
        step();
        chk("R2 higher prio low index", 32'(cpu_vector), 32'd66);

        // R7: zero priority removes line
        for (int i = 0; i < 64; i++) wr(8'(8'h40 + i), 32'd3);
        src_irq = 64'h1 << 10;
        wr(8'h4a, 32'd0);
        step();
        chk("R7 zero prio disables", 32'(cpu_vector), 32'd24);
        wr(8'h4a, 32'd2);
        step();
        chk("R7 nonzero re-enables", 32'(cpu_vector), 32'd74);

        // R4: low three bits of priority byte
        src_irq = 64'h1 << 3;
        wr(8'h43, 32'h0b);
        step();
        chk("R4 level bits", 32'(cpu_level), 32'd3);
        chk("R4 vector", 32'(cpu_vector), 32'd67);
        wr(8'h43, 32'h08);
        step();
        chk("R4 level zero bits", 32'(cpu_level), 32'd0);
        chk("R4 vector still", 32'(cpu_vector), 32'd67);

        // R8: acknowledge read
        rd(8'he0, d);
        chk("R8 ack", d, 32'd67);

        // R5: pending read is live, writes ignored
        src_irq = 64'hA5A5_0F0F_1234_8001;
        #1;
        rd(8'h00, d); chk("R5 pend hi", d, 32'hA5A5_0F0F);
        rd(8'h04, d); chk("R5 pend lo", d, 32'h1234_8001);
        src_irq = '0;
        wr(8'h04, 32'hffff_ffff);
        wr(8'h00, 32'hffff_ffff);
        step();
        rd(8'h04, d); chk("R5 pend write ignored", d, 32'h0);
        chk("R5 no request after write", 32'(cpu_vector), 32'd24);

        // R9: force and mask
        wr(8'h10, 32'h100);
        step();
        chk("R9 forced line", 32'(cpu_vector), 32'd104);
        rd(8'h10, d); chk("R9 force readback", d, 32'h100);
        wr(8'h08, 32'h100);
        step();
        chk("R1 masked forced line", 32'(cpu_vector), 32'd24);
        rd(8'h08, d); chk("R9 mask readback", d, 32'h100);
        wr(8'h08, 32'h0);
        wr(8'h10, 32'h0);

        // R2: mixed random patterns with frequent ties
        for (int it = 0; it < 60; it++) begin
            for (int k = 0; k < 6; k++) begin
                r = rnd();
                wr(8'(8'h40 + r[13:8]), 32'(r[18:16] % 5));
            end
            r = rnd(); wr(8'h0c, r & rnd());
            r = rnd(); wr(8'h14, r & rnd() & rnd());
            src_irq = {rnd(), rnd()};
            step();
            expect_out("R2 random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule